// File: doc/BRIEF.md
# Frame-Indexed Page Lookup Engine

This block translates a (process id, virtual page number) pair into a physical frame number. Its table holds exactly one slot per physical frame, so the table grows with installed memory and not with the size of any address space. Each slot records which page of which process currently lives in that frame. The answer to a lookup is the position of the matching slot.

Scanning every slot would be slow. Instead, a cheap hash of the request picks a starting slot. A short linear walk from that slot finds the entry or gives up. Software fills and clears slots through a direct write port addressed by frame number. A lookup is requested with a valid/ready handshake and finishes with a one-cycle done pulse that carries hit and frame.

Top module: `ipt_lookup`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `done` is 0, and every slot is invalid, so any lookup misses.
- R2: The first slot examined is `(vpn ^ (vpn >> IDX_W) ^ pid) mod FRAMES`, where `IDX_W = log2(FRAMES)` and FRAMES is a power of two (16 by default).
- R3: Slots are examined one per cycle in increasing index order, wrapping from FRAMES-1 to 0. At most PROBES slots (4 by default) are examined. A lookup with no match among them ends as a miss.
- R4: A slot matches only when its valid bit is set and both its stored page number and its stored process id equal the request.
- R5: An invalid slot never matches, but it does not end the walk; the following slots are still examined.
- R6: On a hit, `resp_frame` equals the index of the matching slot. If several slots in the window match, the first one in walk order wins.
- R7: `req_ready` is 1 only while idle. A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from then until the cycle after `done`.
- R8: `done` is high for exactly one cycle. If the lookup is decided at the k-th slot examined, `done` is high in the (k+1)-th cycle after the accepting edge. A miss therefore takes PROBES+1 cycles.
- R9: With `wr_en` high at a rising edge, slot `wr_idx` takes `wr_vpn`, `wr_pid` and valid = `wr_valid`. Writing 0 clears the slot. A slot holds one mapping, so a write replaces the previous mapping of that frame from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_pid | input | PID_W | Process id of the requester |
| done | output | 1 | One-cycle result strobe |
| resp_hit | output | 1 | Result is a hit (valid with `done`) |
| resp_frame | output | IDX_W | Matching frame index (valid with `done` and `resp_hit`) |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W | Frame whose slot is written |
| wr_valid | input | 1 | Valid bit to store (0 clears the slot) |
| wr_vpn | input | VPN_W | Page number to store |
| wr_pid | input | PID_W | Owner process id to store |

## Verification
Several properties are checked every cycle: `done` is a single-cycle pulse, `req_ready` falls after an accepted request and stays low while a result is shown, the walk never runs past its probe limit, a reported frame lies inside the walk window that starts at the hashed slot, and a slot write is visible in the next cycle. Other behaviour only shows in the bench scenarios. These are the hashed start slot, wrap-around at the table end, pid-versus-page discrimination, skipping a cleared slot to reach a later one, first-match priority, replacement of a frame's mapping, and the exact hit and miss latencies.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_DONE  = 2'd2
    } ipt_state_e;

    typedef struct packed {
        logic hit;
        logic last;
    } probe_step_t;

    function automatic probe_step_t eval_step(input logic is_match, input logic at_limit);
        probe_step_t s;
        s.hit  = is_match;
        s.last = is_match | at_limit;
        return s;
    endfunction

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    parameter int IDX_W = 4
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [PID_W-1:0] pid,
    output logic [IDX_W-1:0] start_idx
);
    logic [VPN_W-1:0] vpn_hi;

    always_comb begin
        vpn_hi    = vpn >> IDX_W;
        start_idx = IDX_W'(vpn) ^ IDX_W'(vpn_hi) ^ IDX_W'(pid);
    end
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
    parameter int FRAMES = 16,
    parameter int VPN_W  = 20,
    parameter int PID_W  = 8,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [VPN_W-1:0] rd_vpn,
    output logic [PID_W-1:0] rd_pid
);
    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PID_W-1:0] pid;
    } slot_tag_t;

    logic      valid_q [FRAMES];
    slot_tag_t tag_q   [FRAMES];

    for (genvar g = 0; g < FRAMES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                valid_q[g] <= wr_valid;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(g)) begin
                tag_q[g] <= '{vpn: wr_vpn, pid: wr_pid};
            end
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_vpn   = tag_q[rd_idx].vpn;
        rd_pid   = tag_q[rd_idx].pid;
    end

    // R9: a write lands in the addressed slot by the next cycle
    p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid_q[$past(wr_idx)] == $past(wr_valid)));
endmodule

// File: rtl/ipt_probe_ctl.sv
module ipt_probe_ctl
    import ipt_pkg::*;
#(
    parameter int FRAMES = 16,
    parameter int VPN_W  = 20,
    parameter int PID_W  = 8,
    parameter int PROBES = 4,
    localparam int IDX_W = $clog2(FRAMES),
    localparam int CNT_W = $clog2(PROBES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [PID_W-1:0] req_pid,
    input  logic [IDX_W-1:0] start_idx,
    output logic [IDX_W-1:0] rd_idx,
    input  logic             rd_valid,
    input  logic [VPN_W-1:0] rd_vpn,
    input  logic [PID_W-1:0] rd_pid,
    output logic             done,
    output logic             resp_hit,
    output logic [IDX_W-1:0] resp_frame
);
    ipt_state_e       state_q;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] start_q;
    logic [CNT_W-1:0] steps_q;
    logic [VPN_W-1:0] key_vpn_q;
    logic [PID_W-1:0] key_pid_q;
    logic             hit_q;
    logic [IDX_W-1:0] frame_q;

    logic        slot_match;
    logic        at_limit;
    probe_step_t step;

    always_comb begin
        slot_match = rd_valid && (rd_vpn == key_vpn_q) && (rd_pid == key_pid_q);
        at_limit   = (steps_q == CNT_W'(PROBES - 1));
        step       = eval_step(slot_match, at_limit);
        rd_idx     = ptr_q;
        req_ready  = (state_q == ST_IDLE);
        done       = (state_q == ST_DONE);
        resp_hit   = hit_q;
        resp_frame = frame_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ptr_q     <= '0;
            start_q   <= '0;
            steps_q   <= '0;
            key_vpn_q <= '0;
            key_pid_q <= '0;
            hit_q     <= 1'b0;
            frame_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q   <= ST_PROBE;
                        ptr_q     <= start_idx;
                        start_q   <= start_idx;
                        steps_q   <= '0;
                        key_vpn_q <= req_vpn;
                        key_pid_q <= req_pid;
                    end
                end
                ST_PROBE: begin
                    if (step.last) begin
                        state_q <= ST_DONE;
                        hit_q   <= step.hit;
                        frame_q <= step.hit ? ptr_q : '0;
                    end else begin
                        ptr_q   <= ptr_q + 1'b1;
                        steps_q <= steps_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    logic [IDX_W-1:0] hit_dist;
    always_comb hit_dist = frame_q - start_q;

    // R8: the result strobe lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: an accepted request drops ready
    p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R7: no new request while a result is shown
    p_done_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_ready);

    // R3: the walk never exceeds the probe limit
    p_probe_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROBE) |-> (steps_q < CNT_W'(PROBES)));

    // R6: a reported frame lies in the window that starts at the hashed slot
    p_frame_window_r6: assert property (@(posedge clk) disable iff (rst)
        (done && resp_hit) |-> (int'(hit_dist) < PROBES));
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
    parameter int FRAMES = 16,
    parameter int VPN_W  = 20,
    parameter int PID_W  = 8,
    parameter int PROBES = 4,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [PID_W-1:0] req_pid,
    output logic             done,
    output logic             resp_hit,
    output logic [IDX_W-1:0] resp_frame,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PID_W-1:0] wr_pid
);
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             rd_valid;
    logic [VPN_W-1:0] rd_vpn;
    logic [PID_W-1:0] rd_pid;

    ipt_hash #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)) u_hash (
        .vpn      (req_vpn),
        .pid      (req_pid),
        .start_idx(start_idx)
    );

    ipt_table #(.FRAMES(FRAMES), .VPN_W(VPN_W), .PID_W(PID_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_valid(wr_valid),
        .wr_vpn  (wr_vpn),
        .wr_pid  (wr_pid),
        .rd_idx  (rd_idx),
        .rd_valid(rd_valid),
        .rd_vpn  (rd_vpn),
        .rd_pid  (rd_pid)
    );

    ipt_probe_ctl #(.FRAMES(FRAMES), .VPN_W(VPN_W), .PID_W(PID_W), .PROBES(PROBES)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_vpn   (req_vpn),
        .req_pid   (req_pid),
        .start_idx (start_idx),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_vpn    (rd_vpn),
        .rd_pid    (rd_pid),
        .done      (done),
        .resp_hit  (resp_hit),
        .resp_frame(resp_frame)
    );
endmodule

// File: tb/ipt_lookup_test.sv
`timescale 1ns/1ps
module ipt_lookup_test;
    localparam int FRAMES = 16;
    localparam int VPN_W  = 20;
    localparam int PID_W  = 8;
    localparam int IDX_W  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VPN_W-1:0] req_vpn = '0;
    logic [PID_W-1:0] req_pid = '0;
    logic             done;
    logic             resp_hit;
    logic [IDX_W-1:0] resp_frame;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic             wr_valid = 1'b0;
    logic [VPN_W-1:0] wr_vpn = '0;
    logic [PID_W-1:0] wr_pid = '0;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    ipt_lookup uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_pid(req_pid),
        .done(done), .resp_hit(resp_hit), .resp_frame(resp_frame),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_vpn(wr_vpn), .wr_pid(wr_pid)
    );

    // behavioural reference
    int mvalid [FRAMES];
    int mvpn   [FRAMES];
    int mpid   [FRAMES];
    int mst = 0, mptr = 0, msteps = 0, mkv = 0, mkp = 0, mhit = 0, mframe = 0;

    function automatic int start_of(int v, int p);
        return (v ^ (v >> 4) ^ p) & (FRAMES - 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mst = 0;
            for (int i = 0; i < FRAMES; i++) mvalid[i] = 0;
        end else begin
            case (mst)
                0: if (req_valid) begin
                    mst = 1; mkv = int'(req_vpn); mkp = int'(req_pid);
                    mptr = start_of(mkv, mkp); msteps = 0;
                end
                1: begin
                    if (mvalid[mptr] != 0 && mvpn[mptr] == mkv && mpid[mptr] == mkp) begin
                        mst = 2; mhit = 1; mframe = mptr;
                    end else if (msteps == 3) begin
                        mst = 2; mhit = 0;
                    end else begin
                        mptr = (mptr + 1) % FRAMES; msteps++;
                    end
                end
                default: mst = 0;
            endcase
            if (wr_en) begin
                mvalid[wr_idx] = int'(wr_valid);
                mvpn[wr_idx]   = int'(wr_vpn);
                mpid[wr_idx]   = int'(wr_pid);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            vectors++;
            if (req_ready !== (mst == 0)) begin
                errors++; $display("FAIL R7 ready act=%0b exp=%0b", req_ready, mst == 0);
            end
            vectors++;
            if (done !== (mst == 2)) begin
                errors++; $display("FAIL R8 done act=%0b exp=%0b", done, mst == 2);
            end
            if (done && mst == 2) begin
                vectors++;
                if (resp_hit !== mhit[0]) begin
                    errors++; $display("FAIL R4 hit act=%0b exp=%0d", resp_hit, mhit);
                end
                if (mhit != 0 && int'(resp_frame) != mframe) begin
                    errors++; $display("FAIL R6 frame act=%0d exp=%0d", resp_frame, mframe);
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input int idx, input int v, input int p, input bit val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_vpn = VPN_W'(v); wr_pid = PID_W'(p); wr_valid = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input int v, input int p, output int hit, output int frame, output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_vpn = VPN_W'(v); req_pid = PID_W'(p);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done) begin
            @(negedge clk);
            cyc++;
        end
        hit = int'(resp_hit); frame = int'(resp_frame);
    endtask

    int h, f, c;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 done after reset", int'(done), 0);
        look(18, 3, h, f, c);
        check("R1 empty table misses", h, 0);
        check("R8 miss latency", c, 5);

        // hash of (5,2) is 7
        put(7, 5, 2, 1'b1);
        look(5, 2, h, f, c);
        check("R2 hit at hashed slot", h, 1);
        check("R2 frame", f, 7);
        check("R8 first-slot latency", c, 2);
        look(5, 3, h, f, c);
        check("R4 pid mismatch misses", h, 0);
        look(21, 2, h, f, c);
        check("R4 page mismatch misses", h, 0);

        // hash of (15,0) is 15: walk 15,0,1,2
        put(1, 15, 0, 1'b1);
        look(15, 0, h, f, c);
        check("R3 wrap hit", h, 1);
        check("R3 wrap frame", f, 1);
        check("R8 third-slot latency", c, 4);
        // hash of (30,0) is 15, placed one past the window
        put(3, 30, 0, 1'b1);
        look(30, 0, h, f, c);
        check("R3 beyond window misses", h, 0);

        put(15, 15, 0, 1'b1);
        look(15, 0, h, f, c);
        check("R6 first match wins", f, 15);
        put(15, 15, 0, 1'b0);
        look(15, 0, h, f, c);
        check("R5 cleared slot skipped hit", h, 1);
        check("R5 cleared slot skipped frame", f, 1);

        put(7, 5, 9, 1'b1);
        look(5, 2, h, f, c);
        check("R9 replaced mapping misses", h, 0);
        look(5, 9, h, f, c);
        check("R9 new owner outside window misses", h, 0);

        // request held through done: second lookup must start only after idle
        @(negedge clk);
        req_valid = 1'b1; req_vpn = 20'd15; req_pid = 8'd0;
        repeat (12) @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        check("R7 idle at end", int'(req_ready), 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule